// File: doc/BRIEF.md
# Store Buffer with Byte-Exact Load Forwarding

This block keeps committed stores in program order between a core and a write-back data cache. Each store carries a byte address, a size of 1, 2, 4 or 8 bytes and up to 64 bits of data. The oldest store is offered to the cache on a request/grant drain port. The cache raises the grant only once it owns the target line, and the entry leaves the buffer on that cycle.

Every load is compared against all buffered stores. Only the youngest store whose bytes overlap the load is considered. If that store holds every byte the load needs, and neither access runs past a 64-byte line, the load data comes straight from the buffer, shifted to the load's byte lane, one cycle after the request. If the youngest overlapping store covers only part of the load, or the load is wider, or a line boundary is crossed, the block answers with a replay. The core then reissues the load after the overlapping stores have drained. A load that overlaps no buffered store is told to read the cache.

Top module: `store_fwd_buffer`

## Requirements
- R1: The size code maps 0, 1, 2, 3 to 1, 2, 4, 8 bytes, and store data sits little-endian in the low bytes (bits 7:0 hold the byte at the store address). A store is taken when `st_valid` and `st_ready` are both high. `st_ready` is low while DEPTH entries are held, and a store offered then is not taken.
- R2: `dr_req` is high whenever the buffer is not empty and shows the oldest entry's address, size and data, held steady until granted. The entry is removed on the cycle `dr_gnt` is high. A grant while the buffer is empty has no effect.
- R3: A load whose bytes all lie inside the youngest overlapping store gets `rsp_fwd` one cycle after the request. `rsp_data` bits 7:0 hold the byte at the load address, and bytes beyond the load size are zero.
- R4: A load that the youngest overlapping store covers only partly (it starts before or ends after the store) gets `rsp_replay`.
- R5: A load wider than the youngest overlapping store gets `rsp_replay`.
- R6: Only the youngest overlapping store decides the outcome. An older store that would contain the load does not forward when a younger one overlaps it only partly.
- R7: If the load or the youngest overlapping store runs past a 64-byte line boundary, the load does not forward. It replays when stores overlap it and reads the cache when none do.
- R8: A load that overlaps no buffered store gets `rsp_cache`.
- R9: Exactly one of `rsp_fwd`, `rsp_replay` and `rsp_cache` is high on the cycle after each load request, and none is high after a cycle with no load.
- R10: Forwarding works for a single-byte store with a single-byte load.
- R11: A store accepted in the same cycle as a load is younger than that load and is not seen by it.
- R12: A load looked up in the cycle that the matching oldest entry is granted still sees that entry. Once all overlapping stores have drained, a reissued load gets `rsp_cache`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | 32 | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | 64 | Store data, low bytes used |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | 32 | Load byte address |
| ld_size | input | 2 | Load size code |
| rsp_fwd | output | 1 | Load served from the buffer |
| rsp_replay | output | 1 | Load must be reissued later |
| rsp_cache | output | 1 | Load may read the cache |
| rsp_data | output | 64 | Forwarded load data |
| dr_req | output | 1 | Oldest entry offered to the cache |
| dr_gnt | input | 1 | Cache owns the line and takes the entry |
| dr_addr | output | 32 | Oldest entry address |
| dr_size | output | 2 | Oldest entry size code |
| dr_data | output | 64 | Oldest entry data |

## Verification
Two pairs of functions can share a cycle. In the first, a load lookup lands in the same cycle as the drain grant that removes the very entry the load matches. In the second, a load and a store to the same bytes arrive in the same cycle. The bench provokes both by raising the two inputs on one clock edge. It expects a forward in the first case, because the lookup sees the buffer as it was before the edge, and a cache read in the second, because the new store is younger. A follow-up load in each case then confirms that the entry was removed or has arrived.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int unsigned AW         = 32;
  localparam int unsigned DBYTES     = 8;
  localparam int unsigned DW         = DBYTES * 8;
  localparam int unsigned OFF_W      = $clog2(DBYTES);
  localparam int unsigned LINE_BYTES = 64;
  localparam int unsigned LINE_W     = $clog2(LINE_BYTES);

  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] data_t;
  typedef logic [1:0]    size_t;

  typedef struct packed {
    addr_t addr;
    size_t size;
    data_t data;
  } entry_t;

  // one past the last byte, widened so the sum never wraps
  function automatic logic [AW:0] span_end(addr_t a, size_t s);
    return {1'b0, a} + ({{AW{1'b0}}, 1'b1} << s);
  endfunction

  function automatic logic ranges_overlap(addr_t la, size_t ls, addr_t sa, size_t ss);
    return ({1'b0, la} < span_end(sa, ss)) && ({1'b0, sa} < span_end(la, ls));
  endfunction

  function automatic logic range_within(addr_t la, size_t ls, addr_t sa, size_t ss);
    return (la >= sa) && (span_end(la, ls) <= span_end(sa, ss));
  endfunction

  function automatic logic crosses_line(addr_t a, size_t s);
    logic [31:0] e;
    e = 32'(a[LINE_W-1:0]) + (32'd1 << s);
    return e > 32'(LINE_BYTES);
  endfunction

  // move the byte at offset 'off' down to lane 0 and clear lanes past the load size
  function automatic data_t lane_pick(data_t d, logic [OFF_W-1:0] off, size_t s);
    data_t sh;
    data_t r;
    sh = d >> {off, 3'b000};
    r  = '0;
    for (int b = 0; b < int'(DBYTES); b++)
      if (b < (1 << s)) r[8*b +: 8] = sh[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/sbuf_ring.sv
module sbuf_ring import sbuf_pkg::*; #(
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enq,
  input  entry_t                  enq_ent,
  input  logic                    deq,
  output entry_t [DEPTH-1:0]      ents,
  output logic   [PTR_W-1:0]      head,
  output logic   [CNT_W-1:0]      count,
  output logic                    full,
  output logic                    empty
);
  entry_t [DEPTH-1:0] store_q;
  logic   [PTR_W-1:0] tail;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign ents  = store_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (enq) tail <= bump(tail);
      if (deq) head <= bump(head);
      case ({enq, deq})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (enq) store_q[tail] <= enq_ent;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R1
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    full && !deq |=> full); // R1
endmodule

// File: rtl/sbuf_lookup.sv
module sbuf_lookup import sbuf_pkg::*; #(
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  entry_t [DEPTH-1:0] ents,
  input  logic   [PTR_W-1:0] head,
  input  logic   [CNT_W-1:0] count,
  input  addr_t              ld_addr,
  input  size_t              ld_size,
  output logic               hit,
  output logic               fwd_ok,
  output data_t              fwd_data
);
  logic [PTR_W-1:0] slot [DEPTH];
  logic [DEPTH-1:0] ov_age;   // overlap flag per age, 0 = oldest
  logic [PTR_W-1:0] y_slot;
  entry_t           y_ent;

  for (genvar k = 0; k < int'(DEPTH); k++) begin : g_age
    assign slot[k]   = PTR_W'((int'(head) + k) % int'(DEPTH));
    assign ov_age[k] = (CNT_W'(k) < count) &&
                       ranges_overlap(ld_addr, ld_size, ents[slot[k]].addr, ents[slot[k]].size);
  end

  // later ages overwrite earlier ones, so the youngest overlap wins
  always_comb begin
    hit    = 1'b0;
    y_slot = '0;
    for (int k = 0; k < int'(DEPTH); k++) begin
      if (ov_age[k]) begin
        hit    = 1'b1;
        y_slot = slot[k];
      end
    end
  end

  assign y_ent    = ents[y_slot];
  assign fwd_ok   = hit &&
                    range_within(ld_addr, ld_size, y_ent.addr, y_ent.size) &&
                    !crosses_line(ld_addr, ld_size) &&
                    !crosses_line(y_ent.addr, y_ent.size);
  assign fwd_data = lane_pick(y_ent.data, OFF_W'(ld_addr - y_ent.addr), ld_size);
endmodule

// File: rtl/sbuf_resp.sv
module sbuf_resp import sbuf_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_valid,
  input  logic  hit,
  input  logic  fwd_ok,
  input  data_t fwd_data,
  output logic  rsp_fwd,
  output logic  rsp_replay,
  output logic  rsp_cache,
  output data_t rsp_data
);
  logic live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live       <= 1'b0;
      rsp_fwd    <= 1'b0;
      rsp_replay <= 1'b0;
      rsp_cache  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      live       <= 1'b1;
      rsp_fwd    <= ld_valid && fwd_ok;
      rsp_replay <= ld_valid && hit && !fwd_ok;
      rsp_cache  <= ld_valid && !hit;
      rsp_data   <= (ld_valid && fwd_ok) ? fwd_data : '0;
    end
  end

  AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(ld_valid) |-> $countones({rsp_fwd, rsp_replay, rsp_cache}) == 1); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(ld_valid) |-> !(rsp_fwd || rsp_replay || rsp_cache)); // R9
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer import sbuf_pkg::*; #(
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [1:0]    st_size,
  input  logic [DW-1:0] st_data,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_size,
  output logic          rsp_fwd,
  output logic          rsp_replay,
  output logic          rsp_cache,
  output logic [DW-1:0] rsp_data,
  output logic          dr_req,
  input  logic          dr_gnt,
  output logic [AW-1:0] dr_addr,
  output logic [1:0]    dr_size,
  output logic [DW-1:0] dr_data
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  entry_t [DEPTH-1:0] ents;
  logic   [PTR_W-1:0] head;
  logic   [CNT_W-1:0] count;
  logic               full, empty;
  logic               enq_go, drain_go;
  logic               hit, fwd_ok;
  data_t              fwd_data;
  entry_t             oldest;

  assign enq_go   = st_valid && !full;
  assign drain_go = dr_gnt && !empty;
  assign st_ready = !full;

  sbuf_ring #(.DEPTH(DEPTH)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .enq     (enq_go),
    .enq_ent ('{addr: st_addr, size: st_size, data: st_data}),
    .deq     (drain_go),
    .ents    (ents),
    .head    (head),
    .count   (count),
    .full    (full),
    .empty   (empty)
  );

  sbuf_lookup #(.DEPTH(DEPTH)) u_lookup (
    .ents     (ents),
    .head     (head),
    .count    (count),
    .ld_addr  (ld_addr),
    .ld_size  (ld_size),
    .hit      (hit),
    .fwd_ok   (fwd_ok),
    .fwd_data (fwd_data)
  );

  sbuf_resp u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .hit        (hit),
    .fwd_ok     (fwd_ok),
    .fwd_data   (fwd_data),
    .rsp_fwd    (rsp_fwd),
    .rsp_replay (rsp_replay),
    .rsp_cache  (rsp_cache),
    .rsp_data   (rsp_data)
  );

  assign oldest  = ents[head];
  assign dr_req  = !empty;
  assign dr_addr = oldest.addr;
  assign dr_size = oldest.size;
  assign dr_data = oldest.data;

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dr_req && !dr_gnt |=> dr_req && $stable(dr_addr) && $stable(dr_data)); // R2
  AST_CROSS_NOFWD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && crosses_line(ld_addr, ld_size) |=> !rsp_fwd); // R7
endmodule

// File: tb/tb_store_fwd_buffer.sv
module tb_store_fwd_buffer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, st_ready;
  logic [31:0] st_addr;
  logic [1:0]  st_size;
  logic [63:0] st_data;
  logic        ld_valid;
  logic [31:0] ld_addr;
  logic [1:0]  ld_size;
  logic        rsp_fwd, rsp_replay, rsp_cache;
  logic [63:0] rsp_data;
  logic        dr_req, dr_gnt;
  logic [31:0] dr_addr;
  logic [1:0]  dr_size;
  logic [63:0] dr_data;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] m_a [$];
  logic [1:0]  m_s [$];
  logic [63:0] m_d [$];

  localparam logic [2:0] K_FWD = 3'b100, K_RPL = 3'b010, K_CCH = 3'b001;

  always #5 clk = ~clk;

  store_fwd_buffer dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic [1:0] s, input logic [63:0] d);
    st_valid = 1'b1; st_addr = a; st_size = s; st_data = d;
    @(negedge clk);
    st_valid = 1'b0;
    m_a.push_back(a); m_s.push_back(s); m_d.push_back(d);
  endtask

  task automatic do_load(input logic [31:0] a, input logic [1:0] s, input logic [2:0] ek,
                         input logic [63:0] ed, input string tag);
    ld_valid = 1'b1; ld_addr = a; ld_size = s;
    @(negedge clk);
    ld_valid = 1'b0;
    chk({rsp_fwd, rsp_replay, rsp_cache} == ek, {tag, " kind"},
        64'({rsp_fwd, rsp_replay, rsp_cache}), 64'(ek));
    if (ek == K_FWD) chk(rsp_data == ed, {tag, " data"}, rsp_data, ed);
  endtask

  task automatic drain_one(input string tag);
    chk(dr_req && dr_addr == m_a[0] && dr_size == m_s[0] && dr_data == m_d[0],
        {tag, " oldest"}, 64'(dr_addr), 64'(m_a[0]));
    dr_gnt = 1'b1;
    @(negedge clk);
    dr_gnt = 1'b0;
    void'(m_a.pop_front()); void'(m_s.pop_front()); void'(m_d.pop_front());
  endtask

  task automatic drain_all(input string tag);
    while (m_a.size() > 0) drain_one(tag);
    chk(!dr_req, {tag, " empty"}, 64'(dr_req), 64'd0);
  endtask

  task automatic t_reset();
    chk(st_ready && !dr_req && !rsp_fwd && !rsp_replay && !rsp_cache, "reset R1 R2 R9",
        64'({st_ready, dr_req, rsp_fwd, rsp_replay, rsp_cache}), 64'h10);
  endtask

  task automatic t_contain();
    push(32'h0A, 2'd2, 64'hDDCC_BBAA);
    do_load(32'h0C, 2'd1, K_FWD, 64'hDDCC, "R3 offset 2B in 4B");
    do_load(32'h0D, 2'd0, K_FWD, 64'hDD, "R3 top byte");
    do_load(32'h0A, 2'd2, K_FWD, 64'hDDCC_BBAA, "R3 exact");
    do_load(32'h09, 2'd2, K_RPL, 64'd0, "R4 partial low");
    do_load(32'h0C, 2'd2, K_RPL, 64'd0, "R4 partial high");
    do_load(32'h0A, 2'd3, K_RPL, 64'd0, "R5 wider load");
    drain_all("R2 contain");
  endtask

  task automatic t_byte();
    push(32'h40, 2'd0, 64'h5A);
    do_load(32'h40, 2'd0, K_FWD, 64'h5A, "R10 single byte");
    do_load(32'h40, 2'd1, K_RPL, 64'd0, "R5 2B over 1B");
    do_load(32'h41, 2'd0, K_CCH, 64'd0, "R8 neighbour byte");
    drain_all("R2 byte");
  endtask

  task automatic t_youngest();
    push(32'h200, 2'd3, 64'h8877_6655_4433_2211);
    push(32'h203, 2'd0, 64'hEE);
    do_load(32'h203, 2'd0, K_FWD, 64'hEE, "R6 younger wins");
    do_load(32'h202, 2'd1, K_RPL, 64'd0, "R6 younger partial");
    do_load(32'h204, 2'd1, K_FWD, 64'h6655, "R6 older only");
    drain_one("R2 youngest");
    do_load(32'h202, 2'd1, K_RPL, 64'd0, "R4 after one drain");
    drain_one("R2 youngest");
    do_load(32'h202, 2'd1, K_CCH, 64'd0, "R12 after drain");
  endtask

  task automatic t_line();
    push(32'h138, 2'd3, 64'h0807_0605_0403_0201);
    push(32'h17E, 2'd2, 64'hA4A3_A2A1);
    do_load(32'h13E, 2'd2, K_RPL, 64'd0, "R7 load crosses");
    do_load(32'h13E, 2'd1, K_FWD, 64'h0807, "R3 ends at line edge");
    do_load(32'h17E, 2'd0, K_RPL, 64'd0, "R7 store crosses");
    do_load(32'h7E, 2'd2, K_CCH, 64'd0, "R7 crossing no overlap");
    drain_all("R2 line");
  endtask

  task automatic t_same_cycle();
    st_valid = 1'b1; st_addr = 32'h300; st_size = 2'd2; st_data = 64'h1357_9BDF;
    ld_valid = 1'b1; ld_addr = 32'h300; ld_size = 2'd2;
    @(negedge clk);
    st_valid = 1'b0; ld_valid = 1'b0;
    m_a.push_back(32'h300); m_s.push_back(2'd2); m_d.push_back(64'h1357_9BDF);
    chk({rsp_fwd, rsp_replay, rsp_cache} == K_CCH, "R11 same-cycle store unseen",
        64'({rsp_fwd, rsp_replay, rsp_cache}), 64'(K_CCH));
    do_load(32'h300, 2'd2, K_FWD, 64'h1357_9BDF, "R11 store visible next");
    drain_all("R2 same");
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) push(32'h1000 + 32'(16 * i), 2'd3, 64'hF000 + 64'(i));
    chk(!st_ready, "R1 ready low when full", 64'(st_ready), 64'd0);
    st_valid = 1'b1; st_addr = 32'h2000; st_size = 2'd0; st_data = 64'h77;
    @(negedge clk);
    st_valid = 1'b0;
    chk(!st_ready, "R1 still full", 64'(st_ready), 64'd0);
    do_load(32'h2000, 2'd0, K_CCH, 64'd0, "R1 refused store not taken");
    do_load(32'h1070, 2'd2, K_FWD, 64'hF007, "R3 youngest slot when full");
    drain_one("R2 full");
    chk(st_ready, "R1 ready after drain", 64'(st_ready), 64'd1);
    drain_all("R2 full order");
  endtask

  task automatic t_drain_edge();
    dr_gnt = 1'b1;
    @(negedge clk);
    dr_gnt = 1'b0;
    chk(!dr_req && st_ready, "R2 grant on empty", 64'({dr_req, st_ready}), 64'h1);
    chk(!rsp_fwd && !rsp_replay && !rsp_cache, "R9 no load no response",
        64'({rsp_fwd, rsp_replay, rsp_cache}), 64'd0);
    push(32'h500, 2'd2, 64'hCAFE_F00D);
    push(32'h600, 2'd2, 64'h600D_BEEF);
    // grant of the matching oldest entry in the same cycle as the lookup
    dr_gnt = 1'b1; ld_valid = 1'b1; ld_addr = 32'h502; ld_size = 2'd1;
    @(negedge clk);
    dr_gnt = 1'b0; ld_valid = 1'b0;
    void'(m_a.pop_front()); void'(m_s.pop_front()); void'(m_d.pop_front());
    chk(rsp_fwd && rsp_data == 64'hCAFE, "R12 lookup during grant",
        rsp_data, 64'hCAFE);
    chk(dr_req && dr_addr == 32'h600, "R2 next oldest shown", 64'(dr_addr), 64'h600);
    do_load(32'h502, 2'd1, K_CCH, 64'd0, "R12 entry gone");
    drain_all("R2 edge");
  endtask

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; ld_valid = 1'b0; dr_gnt = 1'b0;
    st_addr = '0; st_size = '0; st_data = '0; ld_addr = '0; ld_size = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_contain();
    t_byte();
    t_youngest();
    t_line();
    t_same_cycle();
    t_full();
    t_drain_edge();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule